// File: doc/BRIEF.md
# Punctured Constraint-Length-7 Convolutional Encoder

This block turns a serial stream of already scrambled data bits into forward-error-corrected code bits ready for PSK symbol mapping. Each accepted input bit goes through a rate 1/2 convolutional mother code with constraint length 7, which produces two parity bits. A puncturing sequencer then removes some of those parity bits to reach a higher code rate. An optional differential pre-encoder comes before the convolutional stage, so that the receiver can resolve the carrier phase ambiguity once it enables the matching differential decoder. A bypass mode passes the data through with no coding.

The rate code, differential enable and bypass pins are captured only while the synchronous reset is held. A new configuration is therefore applied by asserting reset, which also clears the shift register, the differential state and the puncture position. Each accepted bit produces one output beat exactly one clock later. That beat carries one or two code bits.

Top module: `conv_punct_enc`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `out_valid` is 0, `out_num` is 0 and `out_data` is 0. Reset empties the shift register, the differential state and the puncture position, so the first coded bits are computed from an all-zero history.
- R2: Parity X uses generator 171 octal and parity Y uses generator 133 octal. The generator's MSB taps the current bit and its LSB taps the bit six inputs earlier. With rate code 4'b0001 every accepted bit gives `out_num`=2, with X in `out_data[0]` and Y in `out_data[1]`.
- R3: Rate codes 4'b0010, 4'b0011, 4'b0100 and 4'b0101 select rates 2/3, 3/4, 5/6 and 7/8. For each accepted bit at position k of the pattern period, X is kept if character k of the X pattern is 1, and Y is kept if character k of the Y pattern is 1. The patterns are: 2/3 X=10 Y=11; 3/4 X=101 Y=110; 5/6 X=10101 Y=11010; 7/8 X=1000101 Y=1111010. Position 0 is the first bit after reset, and the position wraps at the end of the pattern.
- R4: Every other rate code, including 4'b0000 and codes above 4'b0101, behaves as rate 1/2.
- R5: When the differential enable is 1, the encoder codes d[n] = b[n] XOR d[n-1], with d = 0 before the first bit. When the enable is 0, it codes b[n] directly.
- R6: When bypass is 1, each accepted bit gives `out_num`=1 and `out_data`={1'b0, in_bit}, whatever the rate and differential settings are.
- R7: An output beat appears exactly one cycle after each cycle with `in_valid`=1, and never otherwise. Idle cycles do not move the puncture position or the coder state.
- R8: Configuration pins are sampled only while `rst_n` is low. Changing them while out of reset has no effect on the output.
- R9: When a beat keeps only one code bit, that bit is in `out_data[0]`, `out_data[1]` is 0 and `out_num`=1. When a beat keeps both, `out_num`=2 and X comes before Y. On cycles with no beat, `out_num` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cfg_rate | input | 4 | Code rate selector |
| cfg_diff_en | input | 1 | Differential pre-encoding enable |
| cfg_bypass | input | 1 | Pass input bits through uncoded |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Input data bit |
| out_valid | output | 1 | Output beat strobe |
| out_num | output | 2 | Number of code bits in the beat (0, 1 or 2) |
| out_data | output | 2 | Code bits; bit 0 is sent first |

## Verification
The bench builds the block with its defaults: constraint length 7, generators 171/133, and a longest pattern of 7. With these values every rate pattern wraps many times within a short stream. The bench sweeps every legal rate code and two illegal ones, each with differential on and off and with bypass on and off. Each run is reset separately and carries a pseudo-random stream with periodic idle gaps. This covers pattern wrap, gap handling and all-zero start-up. A further run changes the configuration pins while out of reset, to show that they are ignored.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  localparam int unsigned PUNCT_MAX  = 7;
  localparam int unsigned PUNCT_CW   = $clog2(PUNCT_MAX + 1);
  localparam int unsigned GEN_MAXW   = 32;

  typedef enum logic [3:0] {
    RC_HALF = 4'd1,
    RC_2_3  = 4'd2,
    RC_3_4  = 4'd3,
    RC_5_6  = 4'd4,
    RC_7_8  = 4'd5
  } rate_code_e;

  // bit k of a mask belongs to pattern position k
  typedef struct packed {
    logic [PUNCT_CW-1:0]  period;
    logic [PUNCT_MAX-1:0] x_mask;
    logic [PUNCT_MAX-1:0] y_mask;
  } punct_t;

  function automatic punct_t punct_lookup(input logic [3:0] code);
    punct_t p;
    case (code)
      RC_2_3:  p = '{period: 3'd2, x_mask: 7'b0000001, y_mask: 7'b0000011};
      RC_3_4:  p = '{period: 3'd3, x_mask: 7'b0000101, y_mask: 7'b0000011};
      RC_5_6:  p = '{period: 3'd5, x_mask: 7'b0010101, y_mask: 7'b0001011};
      RC_7_8:  p = '{period: 3'd7, x_mask: 7'b1010001, y_mask: 7'b0101111};
      default: p = '{period: 3'd1, x_mask: 7'b0000001, y_mask: 7'b0000001};
    endcase
    return p;
  endfunction

  // parity of the taps selected by a generator over a window
  function automatic logic tap_parity(input logic [GEN_MAXW-1:0] win,
                                      input logic [GEN_MAXW-1:0] gen);
    return ^(win & gen);
  endfunction

endpackage

// File: rtl/conv_diff.sv
module conv_diff (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vld,
  input  logic bit_in,
  output logic bit_out
);
  logic d_q;

  assign bit_out = en ? (bit_in ^ d_q) : bit_in;

  always_ff @(posedge clk) begin
    if (!rst_n)          d_q <= 1'b0;
    else if (vld && en)  d_q <= bit_out;
  end

  // R5: the differential state moves only on an accepted bit
  p_diff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld && en) |=> $stable(d_q));

endmodule

// File: rtl/conv_core.sv
module conv_core #(
  parameter int unsigned      K   = 7,
  parameter logic [K-1:0]     G_X = 7'o171,
  parameter logic [K-1:0]     G_Y = 7'o133
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic bit_in,
  output logic x_out,
  output logic y_out
);
  import conv_enc_pkg::*;

  localparam int unsigned SR_W = K - 1;
  localparam int unsigned PADW = GEN_MAXW - K;

  logic [SR_W-1:0] sr_q;
  logic [K-1:0]    win;

  // win[K-1] is the current bit, win[0] the oldest held bit
  assign win   = {bit_in, sr_q};
  assign x_out = tap_parity({{PADW{1'b0}}, win}, {{PADW{1'b0}}, G_X});
  assign y_out = tap_parity({{PADW{1'b0}}, win}, {{PADW{1'b0}}, G_Y});

  always_ff @(posedge clk) begin
    if (!rst_n)    sr_q <= '0;
    else if (step) sr_q <= win[K-1:1];
  end

  // R7: idle cycles leave the coder history untouched
  p_sr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sr_q));

  // R2: the newest held bit is the bit accepted on the previous step
  p_sr_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> sr_q[SR_W-1] == $past(bit_in));

endmodule

// File: rtl/conv_punct.sv
module conv_punct (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate,
  input  logic       step,
  output logic       keep_x,
  output logic       keep_y,
  output logic       wrap_evt
);
  import conv_enc_pkg::*;

  punct_t              pat;
  logic [PUNCT_CW-1:0] pos_q;

  assign pat      = punct_lookup(rate);
  assign keep_x   = pat.x_mask[pos_q];
  assign keep_y   = pat.y_mask[pos_q];
  assign wrap_evt = step && (pos_q == pat.period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)        pos_q <= '0;
    else if (wrap_evt) pos_q <= '0;
    else if (step)     pos_q <= pos_q + 1'b1;
  end

  // R3: the position never leaves the active pattern
  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < pat.period);

  // R3: the last position of a period is followed by position 0
  p_pos_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> pos_q == '0);

  // R7: no advance without an accepted bit
  p_pos_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_q));

  // R9: every position keeps at least one code bit
  p_keep_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (keep_x || keep_y));

endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc #(
  parameter int unsigned  K   = 7,
  parameter logic [K-1:0] G_X = 7'o171,
  parameter logic [K-1:0] G_Y = 7'o133
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cfg_rate,
  input  logic       cfg_diff_en,
  input  logic       cfg_bypass,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       out_valid,
  output logic [1:0] out_num,
  output logic [1:0] out_data
);
  import conv_enc_pkg::*;

  logic [3:0] rate_q;
  logic       diff_q;
  logic       byp_q;

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= cfg_rate;
      diff_q <= cfg_diff_en;
      byp_q  <= cfg_bypass;
    end
  end

  logic code_step;
  logic coded_bit;
  logic par_x, par_y;
  logic keep_x, keep_y;
  logic wrap_evt;
  logic half_cfg;

  assign code_step = in_valid && !byp_q;
  assign half_cfg  = (punct_lookup(rate_q).period == 3'd1);

  conv_diff u_diff (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (diff_q),
    .vld    (code_step),
    .bit_in (in_bit),
    .bit_out(coded_bit)
  );

  conv_core #(.K(K), .G_X(G_X), .G_Y(G_Y)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (code_step),
    .bit_in(coded_bit),
    .x_out (par_x),
    .y_out (par_y)
  );

  conv_punct u_punct (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate    (rate_q),
    .step    (code_step),
    .keep_x  (keep_x),
    .keep_y  (keep_y),
    .wrap_evt(wrap_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_num   <= 2'd0;
      out_data  <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (!in_valid) begin
        out_num  <= 2'd0;
        out_data <= 2'b00;
      end else if (byp_q) begin
        out_num  <= 2'd1;
        out_data <= {1'b0, in_bit};
      end else if (keep_x && keep_y) begin
        out_num  <= 2'd2;
        out_data <= {par_y, par_x};
      end else if (keep_x) begin
        out_num  <= 2'd1;
        out_data <= {1'b0, par_x};
      end else begin
        out_num  <= 2'd1;
        out_data <= {1'b0, par_y};
      end
    end
  end

  // R7: one beat per accepted bit, one cycle later
  p_beat_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7: no beat without an accepted bit
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9: beat size is legal, and idle cycles report zero bits
  p_num_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_num == 2'd1 || out_num == 2'd2));
  p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_num == 2'd0 && out_data == 2'b00));

  // R6: bypass echoes the input bit alone
  p_bypass_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byp_q) |=> (out_num == 2'd1 && out_data == {1'b0, $past(in_bit)}));

  // R2 / R4: the unpunctured rate always emits a pair
  p_half_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_step && half_cfg) |=> out_num == 2'd2);

  // R8: configuration holds while out of reset
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(rate_q) && $stable(diff_q) && $stable(byp_q)));

endmodule

// File: tb/test_conv_punct_enc.sv
module test_conv_punct_enc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_rate = 4'd1;
  logic       cfg_diff_en = 1'b0;
  logic       cfg_bypass = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_valid;
  logic [1:0] out_num;
  logic [1:0] out_data;

  always #10 clk = ~clk;

  conv_punct_enc i_conv_punct_enc (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_diff_en(cfg_diff_en),
    .cfg_bypass(cfg_bypass), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_num(out_num), .out_data(out_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  logic [6:0] hist;      // hist[0] = newest coded bit
  logic       dprev;
  int         ppos;
  string      m_px, m_py;
  logic       m_diff, m_byp;
  logic [15:0] lfsr = 16'hACE1;

  // expectation for the beat visible at the next falling edge
  logic       e_valid;
  logic [1:0] e_num;
  logic [1:0] e_data;
  string      e_tag;

  task automatic check_beat();
    n_cmp++;
    if (out_valid !== e_valid || out_num !== e_num || out_data !== e_data) begin
      n_bad++;
      $display("FAIL %s: valid/num/data = %b/%0d/%b expected %b/%0d/%b",
               e_tag, out_valid, out_num, out_data, e_valid, e_num, e_data);
    end
  endtask

  task automatic model_setup(input logic [3:0] rc, input logic d, input logic b);
    hist = '0; dprev = 1'b0; ppos = 0; m_diff = d; m_byp = b;
    case (rc)
      4'd2:    begin m_px = "10";      m_py = "11";      end
      4'd3:    begin m_px = "101";     m_py = "110";     end
      4'd4:    begin m_px = "10101";   m_py = "11010";   end
      4'd5:    begin m_px = "1000101"; m_py = "1111010"; end
      default: begin m_px = "1";       m_py = "1";       end
    endcase
  endtask

  // one clock: check the previous beat, then drive a new input
  task automatic tick(input logic v, input logic b, input string tag);
    logic cb, x, y, kx, ky;
    @(negedge clk);
    check_beat();
    in_valid = v; in_bit = b;
    if (!v) begin
      e_valid = 1'b0; e_num = 2'd0; e_data = 2'b00; e_tag = "R7";
    end else if (m_byp) begin
      e_valid = 1'b1; e_num = 2'd1; e_data = {1'b0, b}; e_tag = "R6";
    end else begin
      cb = m_diff ? (b ^ dprev) : b;
      dprev = cb;
      hist = {hist[5:0], cb};
      x = hist[0] ^ hist[1] ^ hist[2] ^ hist[3] ^ hist[6];   // 171
      y = hist[0] ^ hist[2] ^ hist[3] ^ hist[5] ^ hist[6];   // 133
      kx = (m_px[ppos] == "1");
      ky = (m_py[ppos] == "1");
      ppos = (ppos + 1) % m_px.len();
      e_valid = 1'b1;
      if (kx && ky) begin e_num = 2'd2; e_data = {y, x}; end
      else if (kx)  begin e_num = 2'd1; e_data = {1'b0, x}; end
      else          begin e_num = 2'd1; e_data = {1'b0, y}; end
      e_tag = (e_num == 2'd1) ? {tag, "/R9"} : tag;
    end
  endtask

  task automatic do_reset(input logic [3:0] rc, input logic d, input logic b);
    @(negedge clk);
    check_beat();
    rst_n = 1'b0; in_valid = 1'b0;
    cfg_rate = rc; cfg_diff_en = d; cfg_bypass = b;
    e_valid = 1'b0; e_num = 2'd0; e_data = 2'b00; e_tag = "R1";
    repeat (2) begin
      @(negedge clk);
      check_beat();   // R1: idle while reset is held
    end
    rst_n = 1'b1;
    model_setup(rc, d, b);
  endtask

  function automatic logic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic run_stream(input int nbits, input string tag);
    for (int i = 0; i < nbits; i++) begin
      if (i % 6 == 5) tick(1'b0, 1'b0, "R7");
      tick(1'b1, next_rand(), tag);
    end
    tick(1'b0, 1'b0, "R7");
  endtask

  initial begin
    e_valid = 1'b0; e_num = 2'd0; e_data = 2'b00; e_tag = "R1";
    model_setup(4'd1, 1'b0, 1'b0);

    // R1: first bits after reset from an all-zero history (a single 1 shows the taps)
    do_reset(4'd1, 1'b0, 1'b0);
    tick(1'b1, 1'b1, "R1");
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, "R2");
    tick(1'b0, 1'b0, "R7");

    // sweep: legal rates (R2, R3), illegal codes (R4), differential (R5), bypass (R6)
    for (int rc = 0; rc < 7; rc++) begin
      for (int d = 0; d < 2; d++) begin
        for (int b = 0; b < 2; b++) begin
          logic [3:0] code;
          string tag;
          code = (rc == 6) ? 4'd9 : 4'(rc);
          if (b == 1)                   tag = "R6";
          else if (d == 1)              tag = "R5";
          else if (code == 4'd1)        tag = "R2";
          else if (code >= 4'd2 && code <= 4'd5) tag = "R3";
          else                          tag = "R4";
          do_reset(code, 1'(d), 1'(b));
          run_stream(70, tag);
        end
      end
    end

    // R8: configuration pins changed outside reset are ignored
    do_reset(4'd3, 1'b0, 1'b0);
    run_stream(10, "R8");
    @(negedge clk);
    cfg_rate = 4'd5; cfg_diff_en = 1'b1; cfg_bypass = 1'b1;
    in_valid = 1'b0;
    check_beat();
    e_valid = 1'b0; e_num = 2'd0; e_data = 2'b00; e_tag = "R8";
    run_stream(40, "R8");
    tick(1'b0, 1'b0, "R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule